// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word that a PCI function returns at configuration offset 06h. The function can act as both initiator and target. The bus interface logic sends the block one-cycle event pulses: a parity error was detected, SERR# was driven, a master abort or target abort was received, a target abort was signalled, and PERR# was driven or observed. Alongside each pulse it sends the context of the transaction: the direction, whether this agent was the initiator, the 4-bit bus command, and the parity-response enable from the Command register. The block qualifies each pulse against that context and latches the matching error flag. A flag stays set until software clears it.

Software reads the register through a read-data port that always shows the flags as registered at the last clock edge. Software clears flags by writing 1s through a byte-enabled configuration write port. The DEVSEL timing code and the capability bits are parameters. They read back as constants and cannot be changed by writes. The asynchronous active-low reset takes effect at once and is released through a two-stage synchronizer, so events in the first two cycles after release are not recorded.

Top module: `cfg_status_reg`

## Requirements
- R1: After reset the read data is 16'h0210 with default parameters: all error flags are 0, bits 10:9 are 01 and bit 4 is 1.
- R2: A parity-error pulse sets bit 15 whether or not parity response is enabled.
- R3: A SERR#-driven pulse sets bit 14.
- R4: A master-abort pulse sets bit 13 only when this agent was the initiator and the command is not 4'b0001 (special cycle).
- R5: A received-target-abort pulse sets bit 12 only when this agent was the initiator.
- R6: A signalled-target-abort pulse sets bit 11.
- R7: Bit 8 is set only when all three hold: parity response is enabled, this agent was the initiator, and either PERR# was driven on a read (write flag 0) or observed on a write (write flag 1).
- R8: Bits 10:9 read as the DEVSEL timing parameter (default 01), bit 7 as the fast back-to-back parameter (default 0), bit 5 as the 66 MHz parameter (default 0), and bit 4 as the capabilities-list parameter (default 1). Bits 6 and 3:0 read as 0. No write changes any of these bits.
- R9: A write with byte enable bit 1 set clears every error flag whose data bit is 1. Byte enable bit 1 covers bits 15:8 and bit 0 covers bits 7:0. Data bits of 0, or a write with byte enable bit 1 clear, leave the flags unchanged.
- R10: When a flag's set event and its clear fall in the same cycle, the flag ends up set.
- R11: An event captured at a clock edge appears on the read data after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_par_err | input | 1 | Parity error detected |
| evt_serr_drv | input | 1 | SERR# driven by this function |
| evt_mst_abort | input | 1 | Transaction ended in master abort |
| evt_tabort_rcvd | input | 1 | Target abort received |
| evt_tabort_sig | input | 1 | Target abort signalled by this function |
| evt_perr_drv | input | 1 | PERR# driven by this function |
| evt_perr_obs | input | 1 | PERR# observed on the bus |
| xact_is_write | input | 1 | Current transaction is a write |
| xact_initiator | input | 1 | This agent is initiator of the transaction |
| xact_cmd | input | 4 | Bus command of the transaction |
| par_resp_en | input | 1 | Parity response enable from the Command register |
| cfg_wr_en | input | 1 | Configuration write strobe for this register |
| cfg_wr_be | input | 2 | Byte enables for the write |
| cfg_wr_data | input | 16 | Write data (1 clears a flag) |
| cfg_rd_data | output | 16 | Current register value |

## Verification
Two things can fall in the same cycle: a software clear and a bus event on the same flag. The bench provokes this by driving a parity-error pulse and a write of 1 to bit 15 at the same negative edge. In the same cycle it also clears a different flag and sets SERR#. The bench then expects bit 15 to stay set, the other cleared flag to drop, and bit 14 to rise. A checker assertion holds the same rule over the whole run.

// File: rtl/cfg_status_pkg.sv
package cfg_status_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned BE_W    = REG_W / 8;
  localparam int unsigned N_FLAGS = 6;
  localparam int unsigned CMD_W   = 4;

  localparam logic [CMD_W-1:0] CMD_SPECIAL = 4'b0001;

  // flag indices inside the flag vector
  localparam int unsigned IX_MDPE = 0;
  localparam int unsigned IX_STA  = 1;
  localparam int unsigned IX_RTA  = 2;
  localparam int unsigned IX_RMA  = 3;
  localparam int unsigned IX_SSE  = 4;
  localparam int unsigned IX_DPE  = 5;

  // register bit position of each flag
  function automatic int unsigned flag_pos(int unsigned idx);
    case (idx)
      IX_MDPE: flag_pos = 8;
      IX_STA:  flag_pos = 11;
      IX_RTA:  flag_pos = 12;
      IX_RMA:  flag_pos = 13;
      IX_SSE:  flag_pos = 14;
      default: flag_pos = 15;
    endcase
  endfunction

  typedef struct packed {
    logic par_err;
    logic serr_drv;
    logic mst_abort;
    logic tabort_rcvd;
    logic tabort_sig;
    logic perr_drv;
    logic perr_obs;
  } bus_evt_t;

  typedef struct packed {
    logic             is_write;
    logic             initiator;
    logic [CMD_W-1:0] cmd;
    logic             per_en;
  } xact_ctx_t;
endpackage

// File: rtl/cfg_status_evt_qual.sv
module cfg_status_evt_qual
  import cfg_status_pkg::*;
(
  input  bus_evt_t           evt,
  input  xact_ctx_t          ctx,
  output logic [N_FLAGS-1:0] set_vec
);
  logic perr_as_master;

  always_comb begin
    perr_as_master = ctx.per_en & ctx.initiator &
                     ((evt.perr_drv & ~ctx.is_write) | (evt.perr_obs & ctx.is_write));
    set_vec          = '0;
    set_vec[IX_DPE]  = evt.par_err;
    set_vec[IX_SSE]  = evt.serr_drv;
    set_vec[IX_RMA]  = evt.mst_abort & ctx.initiator & (ctx.cmd != CMD_SPECIAL);
    set_vec[IX_RTA]  = evt.tabort_rcvd & ctx.initiator;
    set_vec[IX_STA]  = evt.tabort_sig;
    set_vec[IX_MDPE] = perr_as_master;
  end
endmodule

// File: rtl/cfg_status_clr_dec.sv
module cfg_status_clr_dec
  import cfg_status_pkg::*;
(
  input  logic               wr_en,
  input  logic [BE_W-1:0]    wr_be,
  input  logic [REG_W-1:0]   wr_data,
  output logic [N_FLAGS-1:0] clr_vec
);
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_clr
    localparam int unsigned POS  = flag_pos(g);
    localparam int unsigned BYTE = POS / 8;
    assign clr_vec[g] = wr_en & wr_be[BYTE] & wr_data[POS];
  end
endmodule

// File: rtl/cfg_status_flag_bank.sv
module cfg_status_flag_bank
  import cfg_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_vec,
  input  logic [N_FLAGS-1:0] clr_vec,
  output logic [N_FLAGS-1:0] flags
);
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    logic q, d, en;

    always_comb begin
      en = set_vec[g] | clr_vec[g];
      d  = set_vec[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end

    assign flags[g] = q;
  end
endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
  import cfg_status_pkg::*;
#(
  parameter logic [1:0] DEVSEL_TIMING = 2'b01,
  parameter bit         FAST_B2B_CAP  = 1'b0,
  parameter bit         MHZ66_CAP     = 1'b0,
  parameter bit         CAP_LIST      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_par_err,
  input  logic             evt_serr_drv,
  input  logic             evt_mst_abort,
  input  logic             evt_tabort_rcvd,
  input  logic             evt_tabort_sig,
  input  logic             evt_perr_drv,
  input  logic             evt_perr_obs,
  input  logic             xact_is_write,
  input  logic             xact_initiator,
  input  logic [3:0]       xact_cmd,
  input  logic             par_resp_en,
  input  logic             cfg_wr_en,
  input  logic [1:0]       cfg_wr_be,
  input  logic [15:0]      cfg_wr_data,
  output logic [15:0]      cfg_rd_data
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  bus_evt_t           evt;
  xact_ctx_t          ctx;
  logic [N_FLAGS-1:0] set_vec, clr_vec, flags;
  logic [REG_W-1:0]   fixed_bits, err_bits;

  always_comb begin
    evt.par_err     = evt_par_err;
    evt.serr_drv    = evt_serr_drv;
    evt.mst_abort   = evt_mst_abort;
    evt.tabort_rcvd = evt_tabort_rcvd;
    evt.tabort_sig  = evt_tabort_sig;
    evt.perr_drv    = evt_perr_drv;
    evt.perr_obs    = evt_perr_obs;
    ctx.is_write    = xact_is_write;
    ctx.initiator   = xact_initiator;
    ctx.cmd         = xact_cmd;
    ctx.per_en      = par_resp_en;
  end

  cfg_status_evt_qual u_qual (
    .evt     (evt),
    .ctx     (ctx),
    .set_vec (set_vec)
  );

  cfg_status_clr_dec u_clr (
    .wr_en   (cfg_wr_en),
    .wr_be   (cfg_wr_be),
    .wr_data (cfg_wr_data),
    .clr_vec (clr_vec)
  );

  cfg_status_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  always_comb begin
    fixed_bits       = '0;
    fixed_bits[10:9] = DEVSEL_TIMING;
    fixed_bits[7]    = FAST_B2B_CAP;
    fixed_bits[5]    = MHZ66_CAP;
    fixed_bits[4]    = CAP_LIST;
    err_bits         = '0;
    for (int i = 0; i < N_FLAGS; i++) err_bits[flag_pos(i)] = flags[i];
    cfg_rd_data      = fixed_bits | err_bits;
  end
endmodule

// File: rtl/cfg_status_reg_chk.sv
module cfg_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_par_err,
  input logic        evt_mst_abort,
  input logic        xact_cmd_special,
  input logic        par_resp_en,
  input logic        cfg_wr_en,
  input logic [1:0]  cfg_wr_be,
  input logic [15:0] cfg_wr_data,
  input logic [15:0] cfg_rd_data
);
  logic clr15;
  assign clr15 = cfg_wr_en & cfg_wr_be[1] & cfg_wr_data[15];

  // R2
  dpe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_par_err |=> cfg_rd_data[15]);

  // R9
  dpe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[15] && !clr15) |=> cfg_rd_data[15]);

  // R9
  dpe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr15 && !evt_par_err) |=> !cfg_rd_data[15]);

  // R4
  rma_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_mst_abort && xact_cmd_special && !cfg_rd_data[13]) |=> !cfg_rd_data[13]);

  // R7
  mdpe_per_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_resp_en && !cfg_rd_data[8]) |=> !cfg_rd_data[8]);

  // R8
  fixed_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> $stable(cfg_rd_data[10:0] & 11'h6FF));
endmodule

bind cfg_status_reg cfg_status_reg_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .evt_par_err      (evt_par_err),
  .evt_mst_abort    (evt_mst_abort),
  .xact_cmd_special (xact_cmd == 4'b0001),
  .par_resp_en      (par_resp_en),
  .cfg_wr_en        (cfg_wr_en),
  .cfg_wr_be        (cfg_wr_be),
  .cfg_wr_data      (cfg_wr_data),
  .cfg_rd_data      (cfg_rd_data)
);

// File: tb/cfg_status_reg_tb.sv
module cfg_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_par_err, evt_serr_drv, evt_mst_abort, evt_tabort_rcvd;
  logic        evt_tabort_sig, evt_perr_drv, evt_perr_obs;
  logic        xact_is_write, xact_initiator, par_resp_en;
  logic [3:0]  xact_cmd;
  logic        cfg_wr_en;
  logic [1:0]  cfg_wr_be;
  logic [15:0] cfg_wr_data;
  logic [15:0] cfg_rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [15:0] BASE = 16'h0210;

  always #2.5 clk = ~clk;

  cfg_status_reg u_dut (.*);

  task automatic chk(input string req, input logic [15:0] exp);
    n_chk++;
    if (cfg_rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, cfg_rd_data, exp);
    end
  endtask

  task automatic idle();
    evt_par_err = 0; evt_serr_drv = 0; evt_mst_abort = 0; evt_tabort_rcvd = 0;
    evt_tabort_sig = 0; evt_perr_drv = 0; evt_perr_obs = 0;
    cfg_wr_en = 0; cfg_wr_be = 2'b00; cfg_wr_data = 16'h0000;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    cfg_wr_en = 1; cfg_wr_be = be; cfg_wr_data = d;
    step();
  endtask

  task automatic ctx(input logic w, input logic init, input logic [3:0] c, input logic per);
    xact_is_write = w; xact_initiator = init; xact_cmd = c; par_resp_en = per;
  endtask

  task automatic t_reset();
    chk("R1 reset value", BASE);
  endtask

  task automatic t_dpe_sse_sta();
    ctx(0, 0, 4'h6, 0);
    evt_par_err = 1; step();
    chk("R2 parity with response off", BASE | 16'h8000);
    evt_serr_drv = 1; step();
    chk("R3 serr", BASE | 16'hC000);
    evt_tabort_sig = 1; step();
    chk("R6 signalled target abort", BASE | 16'hC800);
    wr(2'b10, 16'hC800);
    chk("R9 clear all three", BASE);
  endtask

  task automatic t_rma();
    ctx(0, 1, 4'b0001, 0);
    evt_mst_abort = 1; step();
    chk("R4 special cycle ignored", BASE);
    ctx(0, 0, 4'h6, 0);
    evt_mst_abort = 1; step();
    chk("R4 not initiator ignored", BASE);
    ctx(0, 1, 4'h6, 0);
    evt_mst_abort = 1; step();
    chk("R4 master abort as initiator", BASE | 16'h2000);
    wr(2'b10, 16'h2000);
  endtask

  task automatic t_rta();
    ctx(1, 0, 4'h7, 0);
    evt_tabort_rcvd = 1; step();
    chk("R5 not initiator ignored", BASE);
    ctx(1, 1, 4'h7, 0);
    evt_tabort_rcvd = 1; step();
    chk("R5 target abort received", BASE | 16'h1000);
    wr(2'b10, 16'h1000);
  endtask

  task automatic t_mdpe();
    ctx(0, 1, 4'h6, 0);
    evt_perr_drv = 1; step();
    chk("R7 response disabled", BASE);
    ctx(0, 0, 4'h6, 1);
    evt_perr_drv = 1; step();
    chk("R7 not initiator", BASE);
    ctx(1, 1, 4'h7, 1);
    evt_perr_drv = 1; step();
    chk("R7 driven on write", BASE);
    ctx(0, 1, 4'h6, 1);
    evt_perr_obs = 1; step();
    chk("R7 observed on read", BASE);
    evt_perr_drv = 1; step();
    chk("R7 driven on read", BASE | 16'h0100);
    wr(2'b10, 16'h0100);
    chk("R9 clear bit 8", BASE);
    ctx(1, 1, 4'h7, 1);
    evt_perr_obs = 1; step();
    chk("R7 observed on write", BASE | 16'h0100);
    wr(2'b10, 16'h0100);
  endtask

  task automatic t_write_rules();
    ctx(0, 1, 4'h6, 1);
    wr(2'b11, 16'hFFFF);
    chk("R8 fixed bits unchanged by write", BASE);
    evt_par_err = 1; evt_serr_drv = 1; evt_tabort_sig = 1; evt_perr_drv = 1;
    evt_mst_abort = 1; evt_tabort_rcvd = 1; step();
    chk("R9 all flags set", BASE | 16'hF900);
    wr(2'b01, 16'hFFFF);
    chk("R9 low byte enable has no effect", BASE | 16'hF900);
    wr(2'b11, 16'h0000);
    chk("R9 zero data has no effect", BASE | 16'hF900);
    wr(2'b10, 16'h0900);
    chk("R9 partial clear", BASE | 16'hF000);
    wr(2'b10, 16'hFFFF);
    chk("R9 full clear", BASE);
  endtask

  task automatic t_collide();
    ctx(0, 0, 4'h6, 0);
    evt_tabort_sig = 1; step();
    evt_par_err = 1; evt_serr_drv = 1;
    cfg_wr_en = 1; cfg_wr_be = 2'b10; cfg_wr_data = 16'h8800;
    step();
    chk("R10 set wins over clear", BASE | 16'hC000);
    wr(2'b10, 16'hFFFF);
  endtask

  task automatic t_timing();
    ctx(0, 0, 4'h6, 0);
    evt_tabort_sig = 1;
    @(posedge clk); #1.5;
    evt_tabort_sig = 0;
    chk("R11 visible after capture edge", BASE | 16'h0800);
    @(negedge clk);
    wr(2'b10, 16'h0800);
    evt_serr_drv = 1;
    #1.5;
    chk("R11 not visible before edge", BASE);
    step();
    chk("R11 visible after edge", BASE | 16'h4000);
    wr(2'b10, 16'h4000);
  endtask

  initial begin
    idle();
    ctx(0, 0, 4'h0, 0);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_dpe_sse_sta();
    t_rma();
    t_rta();
    t_mdpe();
    t_write_rules();
    t_collide();
    t_timing();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule